// File: doc/BRIEF.md
# Short Frame Pad and CRC Appender

This stage sits on the transmit byte path between the descriptor-fetch logic and the MAC. It forwards each frame byte with no added latency and then, as the frame's controls require, emits zero bytes and a four-byte IEEE 802.3 frame check sequence. Each frame arrives with a start marker on its first byte and an end marker on its last byte. Two per-frame controls arrive alongside every byte: `in_nopad`, which suppresses padding, and `in_nocrc`, which suppresses the check sequence. The stage reads these controls only from the first byte of a frame. When padding is allowed, the check sequence is always appended, whatever `in_nocrc` says.

A state machine with four named states does the work. `ST_IDLE` waits for a start byte. `ST_BODY` forwards the remaining frame bytes. `ST_PAD` emits zero bytes. `ST_FCS` emits the four check bytes.

The transitions are these:
- `IDLE->BODY`: the start byte is taken and is not the end byte.
- `IDLE/BODY->PAD`: the end byte is taken, padding is allowed, and the body so far is shorter than 60 bytes.
- `IDLE/BODY->FCS`: the end byte is taken, no padding is needed, and a check sequence is due.
- `IDLE/BODY->IDLE`: the end byte is taken and neither padding nor a check sequence is due.
- `PAD->FCS`: the 60th body byte is emitted.
- `FCS->IDLE`: the fourth check byte is emitted.

Both sides use valid/ready handshakes. While the stage emits generated bytes, it holds its input not-ready.

Top module: `tx_tail_stage`

## Requirements
- R1: Each data byte taken at the input appears at the output in the same cycle, unchanged and in order. `out_sof` is high on the first byte of each frame only.
- R2: When the frame's first byte has `in_nopad`=0 and the frame holds fewer than 60 data bytes, zero bytes follow the data until data plus padding total 60 bytes. A frame of 60 or more data bytes gets no padding.
- R3: A check sequence of 4 bytes follows the body when `in_nopad`=0, or when `in_nocrc`=0. The sequence is CRC-32: reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, final inversion. It covers the data and padding bytes and is sent least significant byte first. The bytes "123456789" give the check value 0xCBF43926.
- R4: When the first byte has both `in_nopad`=1 and `in_nocrc`=1, the frame leaves with no byte appended.
- R5: When the first byte has `in_nopad`=1, a frame shorter than 60 bytes leaves unpadded.
- R6: The values of `in_nopad` and `in_nocrc` on any byte after the first byte of a frame have no effect on that frame's output.
- R7: `out_eof` is high on exactly the last byte emitted for a frame, whether that byte is data, padding or check byte. After that byte the stage is idle.
- R8: `in_ready` is low in every cycle in which a padding byte or a check byte is being offered.
- R9: While `out_ready` is low, a generated byte that is on offer stays on offer with the same value and the same end marker.
- R10: A byte offered while the stage is idle without `in_sof` is accepted and discarded, and produces no output.
- R11: After reset, `out_valid` is low and the stage is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input byte is offered |
| in_ready | output | 1 | The stage takes the offered byte this cycle |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_nopad | input | 1 | Suppresses padding; read only with the first byte |
| in_nocrc | input | 1 | Suppresses the check sequence when padding is also off; read only with the first byte |
| out_valid | output | 1 | An output byte is offered |
| out_ready | input | 1 | The downstream stage takes the offered byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Marks the first output byte of a frame |
| out_eof | output | 1 | Marks the last output byte of a frame |

## Verification
The assertions check five things on every cycle:
- A byte taken from the input leaves at once and unchanged.
- A generated byte on offer holds steady under backpressure.
- The end marker returns the machine to idle.
- The check sequence of a padded frame follows a body of at least 60 bytes.
- After the last check byte, the running CRC over the whole frame equals the fixed residue 0xDEBB20E3.

Some properties need whole frames, and only the scoreboard scenarios can show them. These are the exact padding count at the 59/60/61-byte boundaries, the byte order of the check sequence, and that controls on later segments are ignored. The same holds for how padding and CRC suppression interact, and for discarding a stray byte that has no start marker.

// File: rtl/tail_pkg.sv
package tail_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_PAD  = 2'd2,
        ST_FCS  = 2'd3
    } tail_state_t;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB_20E3;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc_byte_step(input logic [31:0] c_in,
                                                  input logic [7:0]  d);
        logic [31:0] c;
        c = c_in ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/tail_crc_unit.sv
module tail_crc_unit
    import tail_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          upd,
    input  logic [DW-1:0] din,
    output logic [31:0]   crc_q,
    output logic [31:0]   crc_d
);

    logic [31:0] seed;

    // A new frame restarts from the seed value.
    always_comb begin
        seed  = start ? CRC_SEED : crc_q;
        crc_d = crc_byte_step(seed, din[7:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (upd) begin
            crc_q <= crc_d;
        end
    end

endmodule

// File: rtl/tail_len_counter.sv
module tail_len_counter #(
    parameter int MAXV = 60,
    localparam int CW  = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    logic [CW-1:0] base;
    logic [CW-1:0] nxt;

    // Saturates at MAXV: only "reached the minimum" matters.
    always_comb begin
        base = start ? '0 : cnt;
        nxt  = (base >= CW'(MAXV)) ? CW'(MAXV) : base + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= nxt;
        end
    end

endmodule

// File: rtl/tx_tail_stage.sv
module tx_tail_stage
    import tail_pkg::*;
#(
    parameter int MIN_BODY = 60,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_nopad,
    input  logic          in_nocrc,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_sof,
    output logic          out_eof
);

    localparam int FCS_BYTES = 32 / DW;
    localparam int IDX_W     = $clog2(FCS_BYTES);
    localparam int CW        = $clog2(MIN_BODY + 1);

    tail_state_t    state_q, state_d;
    logic           pad_en_q, crc_en_q;
    logic [31:0]    fcs_hold;
    logic [IDX_W-1:0] fcs_idx;
    logic [CW-1:0]  body_cnt;
    logic [31:0]    crc_q, crc_d;

    logic           idle;
    logic           fire;
    logic           eff_pad_en, eff_crc_en;
    logic [CW:0]    body_after;
    logic           need_pad;
    logic           tail_after_end;
    logic           body_beat;

    assign idle = (state_q == ST_IDLE);

    // Controls come straight from the port on the first byte and from the latch afterwards.
    always_comb begin
        eff_pad_en     = idle ? !in_nopad : pad_en_q;
        eff_crc_en     = idle ? (!in_nopad || !in_nocrc) : crc_en_q;
        body_after     = idle ? (CW+1)'(1) : ({1'b0, body_cnt} + (CW+1)'(1));
        need_pad       = eff_pad_en && (body_after < (CW+1)'(MIN_BODY));
        tail_after_end = need_pad || eff_crc_en;
    end

    // Output process
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_sof   = 1'b0;
        out_eof   = 1'b0;
        in_ready  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                out_valid = in_valid && in_sof;
                out_data  = in_data;
                out_sof   = 1'b1;
                out_eof   = in_eof && !tail_after_end;
                in_ready  = in_sof ? out_ready : 1'b1;
            end
            ST_BODY: begin
                out_valid = in_valid;
                out_data  = in_data;
                out_eof   = in_eof && !tail_after_end;
                in_ready  = out_ready;
            end
            ST_PAD: begin
                out_valid = 1'b1;
                out_data  = '0;
            end
            ST_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs_hold[DW*fcs_idx +: DW];
                out_eof   = (fcs_idx == IDX_W'(FCS_BYTES - 1));
            end
        endcase
    end

    assign fire      = out_valid && out_ready;
    assign body_beat = fire && (state_q != ST_FCS);

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_BODY: begin
                if (fire) begin
                    if (!in_eof)       state_d = ST_BODY;
                    else if (need_pad) state_d = ST_PAD;
                    else if (eff_crc_en) state_d = ST_FCS;
                    else               state_d = ST_IDLE;
                end
            end
            ST_PAD: begin
                if (fire && (body_cnt == CW'(MIN_BODY - 1))) state_d = ST_FCS;
            end
            ST_FCS: begin
                if (fire && out_eof) state_d = ST_IDLE;
            end
        endcase
    end

    // State register and per-frame latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pad_en_q <= 1'b0;
            crc_en_q <= 1'b0;
            fcs_hold <= '0;
            fcs_idx  <= '0;
        end else begin
            state_q <= state_d;
            if (idle && fire) begin
                pad_en_q <= !in_nopad;
                crc_en_q <= !in_nopad || !in_nocrc;
            end
            if (state_d == ST_FCS && state_q != ST_FCS) begin
                fcs_hold <= ~crc_d;
                fcs_idx  <= '0;
            end else if (state_q == ST_FCS && fire) begin
                fcs_idx <= fcs_idx + IDX_W'(1);
            end
        end
    end

    tail_crc_unit #(.DW(DW)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (idle),
        .upd   (fire),
        .din   (out_data),
        .crc_q (crc_q),
        .crc_d (crc_d)
    );

    tail_len_counter #(.MAXV(MIN_BODY)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .start (idle),
        .inc   (body_beat),
        .cnt   (body_cnt)
    );

    // R1: a byte taken from the input leaves at once, unchanged
    a_r1_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(idle && !in_sof)) |-> (out_valid && out_ready && out_data == in_data));

    // R2: a padded frame reaches its check sequence only after the minimum body
    a_r2_min_body: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FCS && pad_en_q) |-> (body_cnt >= CW'(MIN_BODY)));

    // R3: the CRC over body plus check bytes ends on the fixed residue
    a_r3_fcs_residue: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FCS && fire && out_eof) |=> (crc_q == CRC_RESIDUE));

    // R7: the end marker returns the stage to idle
    a_r7_eof_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_eof) |=> idle);

    // R9: a generated byte holds while stalled
    a_r9_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && (state_q == ST_PAD || state_q == ST_FCS))
        |=> (out_valid && $stable(out_data) && $stable(out_eof)));

endmodule

// File: tb/sim_tx_tail_stage.sv
module sim_tx_tail_stage;
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct {
        logic [7:0] d;
        logic       s;
        logic       e;
        logic       tail;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic       in_nopad = 1'b0, in_nocrc = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, out_sof, out_eof;
    logic [7:0] out_data;
    logic       out_ready;
    logic       rnd_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    exp_t       sb[$];
    exp_t       cur;
    logic [7:0] bq[$];
    int         checks = 0, errors = 0, unexpected = 0, cycles = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    assign out_ready = rnd_mode ? (lfsr[0] | lfsr[5]) : 1'b1;

    tx_tail_stage u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_nopad(in_nopad), .in_nocrc(in_nocrc),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc_step(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in ^ {24'd0, d};
        for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    unexpected++;
                    chk(1'b0, "R10", "unexpected output byte", out_data, 0);
                end else begin
                    cur = sb.pop_front();
                    chk(out_data == cur.d, cur.tag, "byte value", out_data, cur.d);
                    chk(out_sof == cur.s, "R1", "start marker", out_sof, cur.s);
                    chk(out_eof == cur.e, "R7", "end marker", out_eof, cur.e);
                    if (cur.tail) chk(in_ready == 1'b0, "R8", "input ready during tail", in_ready, 0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    // Called at a negedge; returns at the negedge after the byte is taken.
    task automatic push_byte(input logic [7:0] d, input bit s, input bit e,
                             input bit np, input bit nc);
        bit go;
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        in_nopad = np; in_nocrc = nc;
        do begin
            #1;
            go = in_ready;
            @(negedge clk);
        end while (!go);
    endtask

    task automatic make_body(input int n, input int seed);
        bq.delete();
        for (int i = 0; i < n; i++) bq.push_back(8'(seed + i * 7 + 1));
    endtask

    task automatic send_frame(input bit np, input bit nc, input bit flip);
        exp_t q[$];
        exp_t t;
        logic [31:0] c;
        int n;
        bit pad_en, crc_en;
        pad_en = !np;
        crc_en = pad_en || !nc;
        c = 32'hFFFFFFFF;
        n = bq.size();
        for (int i = 0; i < n; i++) begin
            q.push_back('{bq[i], (i == 0), 1'b0, 1'b0, "R1"});
            c = ref_crc_step(c, bq[i]);
        end
        if (pad_en) begin
            for (int i = n; i < 60; i++) begin
                q.push_back('{8'h00, 1'b0, 1'b0, 1'b1, "R2"});
                c = ref_crc_step(c, 8'h00);
            end
        end
        if (crc_en) begin
            c = ~c;
            for (int k = 0; k < 4; k++) q.push_back('{c[8*k +: 8], 1'b0, 1'b0, 1'b1, "R3"});
        end
        t = q[q.size() - 1];
        t.e = 1'b1;
        q[q.size() - 1] = t;
        foreach (q[i]) sb.push_back(q[i]);
        for (int i = 0; i < n; i++) begin
            if (i == 0) push_byte(bq[i], 1'b1, (n == 1), np, nc);
            else        push_byte(bq[i], 1'b0, (i == n - 1), flip ? !np : np, flip ? !nc : nc);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic drain;
        int w;
        w = 0;
        while (sb.size() != 0 && w < 2000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R7", "all expected bytes emitted", sb.size(), 0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R11", "idle input ready", in_ready, 1);
        @(negedge clk);

        // Reference check vector for R3
        v = 32'hFFFFFFFF;
        for (int i = 0; i < 9; i++) v = ref_crc_step(v, 8'h31 + 8'(i));
        chk(~v == 32'hCBF43926, "R3", "check value of 123456789", ~v, 32'hCBF43926);
        bq.delete();
        for (int i = 0; i < 9; i++) bq.push_back(8'h31 + 8'(i));
        send_frame(1'b1, 1'b0, 1'b0);   // R3: no pad, CRC only
        drain();

        make_body(10, 3);  send_frame(1'b0, 1'b1, 1'b0); drain();  // R2/R3: pad forces CRC
        make_body(12, 9);  send_frame(1'b1, 1'b1, 1'b0); drain();  // R4/R5: nothing appended
        make_body(70, 20); send_frame(1'b0, 1'b0, 1'b0); drain();  // R3: long frame, no pad
        make_body(60, 40); send_frame(1'b0, 1'b0, 1'b0); drain();  // R2: exactly minimum
        make_body(59, 50); send_frame(1'b0, 1'b1, 1'b0); drain();  // R2: one pad byte
        make_body(1, 60);  send_frame(1'b0, 1'b0, 1'b0); drain();  // R2/R7: single-byte frame
        make_body(8, 70);  send_frame(1'b1, 1'b1, 1'b1); drain();  // R6: later controls ignored
        make_body(8, 80);  send_frame(1'b0, 1'b0, 1'b1); drain();  // R6: later controls ignored

        // R10: stray byte without start marker while idle
        in_valid = 1'b1; in_data = 8'hA5; in_sof = 1'b0; in_eof = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R10", "stray byte accepted", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(unexpected == 0, "R10", "stray byte produced output", unexpected, 0);

        // R9: backpressure across several frames
        rnd_mode = 1'b1;
        make_body(5, 90);  send_frame(1'b0, 1'b0, 1'b0);
        make_body(64, 91); send_frame(1'b1, 1'b0, 1'b0);
        make_body(30, 92); send_frame(1'b0, 1'b1, 1'b1);
        make_body(3, 93);  send_frame(1'b1, 1'b1, 1'b0);
        drain();
        rnd_mode = 1'b0;
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule